// File: doc/BRIEF.md
# Interrupt Source Gating and Routing

This block owns the configuration of a bank of interrupt sources and turns their request lines into per-CPU delivery pulses. Each source carries a vector/priority word and a destination word. On every clock the block samples all request lines, decides for each source whether the request is accepted, and raises one-cycle pulses toward the CPUs chosen for it. The per-CPU queues downstream consume those pulses. They report back which sources they already hold raised and strobe an activity clear when a source has been acknowledged.

A source can be routed in two ways. In the first, every listed CPU that can accept it receives a pulse. In the second, a single listed CPU receives it, and that CPU is picked round-robin. Each source has an activity flag that only hardware changes. While the flag is set, further requests from that source are refused, and its sense and polarity settings cannot be changed. Software reaches the words through a 32-bit port addressed by a source index and a word select.

Top module: `irq_route_gate`

## Requirements
- R1: After reset every vector/priority word reads 0xA0000000 (masked, mode bit set) and every destination word reads 0; no delivery pulse is present.
- R2: Select 0 addresses the vector/priority word and select 1 the destination word. Read data appears one cycle after index and select are presented. Vector/priority layout: bit 31 mask (1 blocks), bit 30 activity, bit 29 mode (0 all listed CPUs, 1 one CPU), bit 23 polarity, bit 22 sense (1 level, 0 rising edge), bits 19:16 priority, bits 7:0 vector. All other bits read 0. A write always updates mask, mode, priority and vector, and never changes activity.
- R3: A request has no effect, and activity stays clear, when the source is masked, when its priority is 0, or when its destination mask (low NUM_CPU bits) is zero.
- R4: A request from a source whose activity bit is set produces no pulse, including a level request that is held.
- R5: A level source whose request goes inactive while active has its activity cleared. A level request that is still held once activity is clear is taken again.
- R6: With mode 0, or with a destination mask that holds only the last-served CPU, every listed eligible CPU receives a pulse.
- R7: With mode 1, only the first CPU listed in the destination mask after the last-served CPU (wrapping modulo NUM_CPU) is tried. That CPU becomes last-served. Last-served resets to CPU 0.
- R8: Polarity and sense are writable only on sources with index below NUM_EXT, and only while activity is clear. On other sources they read 0.
- R9: A destination write keeps bits 31:30 and the low NUM_CPU bits; all other bits read 0.
- R10: CPU c is eligible when the source priority is strictly greater than its task priority and its raised bit for the source is clear. A delivery to at least one CPU sets activity. The pulse is on deliver_o bit s*NUM_CPU+c, one cycle after the request is sampled.
- R11: A pulse on act_clr_i[s] clears source s's activity, and the next request is then accepted.
- R12: With polarity 1 the request line is active low, so an edge source fires on a falling input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Raw source request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | clog2(NUM_SRC) | Source index |
| cfg_sel_i | input | 1 | 0 vector/priority word, 1 destination word |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Registered read data |
| cpu_prio_i | input | 4*NUM_CPU | Task priority per CPU, CPU c at bits 4c+3:4c |
| raised_i | input | NUM_SRC*NUM_CPU | Source s already raised at CPU c, bit s*NUM_CPU+c |
| act_clr_i | input | NUM_SRC | Activity clear strobe per source |
| deliver_o | output | NUM_SRC*NUM_CPU | Delivery pulse, bit s*NUM_CPU+c |

## Verification
The hardest state to reach from the ports is a source whose activity bit is set at the same moment software tries to rewrite its sense field. The activity bit cannot be written, so the stimulus first holds a level request until the source is delivered. It then writes a new sense and vector while the request is still held, reads the word back, and checks that only the vector changed. The round-robin pointer is also not visible, so it is checked indirectly: repeated requests are each followed by a clear strobe, and the sequence of pulsed CPUs must walk through the destination mask and wrap.

// File: rtl/irq_rg_pkg.sv
`timescale 1ns/1ps
package irq_rg_pkg;
  localparam int VP_MASK    = 31;
  localparam int VP_ACT     = 30;
  localparam int VP_MODE    = 29;
  localparam int VP_POL     = 23;
  localparam int VP_SENSE   = 22;
  localparam int VP_PRIO_LO = 16;
  localparam int PRIO_W     = 4;
  localparam int VEC_W      = 8;

  typedef struct packed {
    logic              mask;
    logic              mode;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } vp_cfg_t;

  function automatic logic [31:0] pack_vp(vp_cfg_t c, logic act);
    logic [31:0] w;
    w = '0;
    w[VP_MASK]  = c.mask;
    w[VP_ACT]   = act;
    w[VP_MODE]  = c.mode;
    w[VP_POL]   = c.pol;
    w[VP_SENSE] = c.sense;
    w[VP_PRIO_LO +: PRIO_W] = c.prio;
    w[VEC_W-1:0] = c.vec;
    return w;
  endfunction
endpackage

// File: rtl/irq_rg_cfg.sv
`timescale 1ns/1ps
module irq_rg_cfg
  import irq_rg_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter bit IS_EXT  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_vp_i,
  input  logic               we_dst_i,
  input  logic [31:0]        wdata_i,
  input  logic               act_set_i,
  input  logic               act_clr_i,
  output vp_cfg_t            cfg_o,
  output logic               act_o,
  output logic [NUM_CPU-1:0] dest_o,
  output logic [31:0]        vp_word_o,
  output logic [31:0]        dst_word_o
);
  vp_cfg_t            cfg_q;
  logic               act_q;
  logic [1:0]         dhi_q;
  logic [NUM_CPU-1:0] dmask_q;
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mask  <= 1'b1;
      cfg_q.mode  <= 1'b1;
      cfg_q.pol   <= 1'b0;
      cfg_q.sense <= 1'b0;
      cfg_q.prio  <= '0;
      cfg_q.vec   <= '0;
    end else if (we_vp_i) begin
      cfg_q.mask <= wdata_i[VP_MASK];
      cfg_q.mode <= wdata_i[VP_MODE];
      cfg_q.prio <= wdata_i[VP_PRIO_LO +: PRIO_W];
      cfg_q.vec  <= wdata_i[VEC_W-1:0];
      if (IS_EXT && !act_q) begin
        cfg_q.pol   <= wdata_i[VP_POL];
        cfg_q.sense <= wdata_i[VP_SENSE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dhi_q   <= '0;
      dmask_q <= '0;
    end else if (we_dst_i) begin
      dhi_q   <= wdata_i[31:30];
      dmask_q <= wdata_i[NUM_CPU-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            act_q <= 1'b0;
    else if (act_set_i) act_q <= 1'b1;
    else if (act_clr_i) act_q <= 1'b0;
  end

  always_comb begin
    dst_word_o = '0;
    dst_word_o[31:30] = dhi_q;
    dst_word_o[NUM_CPU-1:0] = dmask_q;
  end

  assign cfg_o     = cfg_q;
  assign act_o     = act_q;
  assign dest_o    = dmask_q;
  assign vp_word_o = pack_vp(cfg_q, act_q);

  AST_SENSE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    act_q |=> $stable({cfg_q.pol, cfg_q.sense})); // R8

  AST_ACT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    act_set_i |=> act_q); // R10
endmodule

// File: rtl/irq_rg_detect.sv
`timescale 1ns/1ps
module irq_rg_detect (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic pol_i,
  input  logic sense_i,
  input  logic act_i,
  output logic assert_o,
  output logic drop_o
);
  logic active;
  logic prev_q;

  assign active = req_i ^ pol_i;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= active;
  end

  assign assert_o = sense_i ? active : (active & ~prev_q);
  assign drop_o   = sense_i & act_i & ~active;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (assert_o && !sense_i) |=> !(assert_o && !sense_i && $stable(pol_i) && $stable(sense_i))); // R4
endmodule

// File: rtl/irq_rg_route.sv
`timescale 1ns/1ps
module irq_rg_route
  import irq_rg_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       evt_i,
  input  logic                       act_i,
  input  logic                       mask_i,
  input  logic                       mode_i,
  input  logic [PRIO_W-1:0]          prio_i,
  input  logic [NUM_CPU-1:0]         dest_i,
  input  logic [NUM_CPU*PRIO_W-1:0]  cpu_prio_i,
  input  logic [NUM_CPU-1:0]         raised_i,
  output logic [NUM_CPU-1:0]         tgt_o
);
  logic [CPU_W-1:0]   last_q;
  logic [CPU_W-1:0]   pick_idx;
  logic [NUM_CPU-1:0] pick_oh;
  logic [NUM_CPU-1:0] elig;
  logic               gate_ok;
  logic               fire;
  logic               directed;
  logic               found;

  assign gate_ok  = !mask_i && (prio_i != '0) && (|dest_i);
  assign fire     = evt_i && !act_i && gate_ok;
  assign directed = !mode_i || (dest_i == (NUM_CPU'(1) << last_q));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_elig
    assign elig[c] = (prio_i > cpu_prio_i[c*PRIO_W +: PRIO_W]) && !raised_i[c];
  end

  always_comb begin
    found    = 1'b0;
    pick_idx = last_q;
    for (int k = 1; k <= NUM_CPU; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= NUM_CPU) idx = idx - NUM_CPU;
      if (!found && dest_i[idx]) begin
        found    = 1'b1;
        pick_idx = CPU_W'(idx);
      end
    end
    pick_oh = NUM_CPU'(1) << pick_idx;
  end

  always_comb begin
    tgt_o = '0;
    if (fire) tgt_o = directed ? (dest_i & elig) : (pick_oh & elig);
  end

  always_ff @(posedge clk) begin
    if (rst)                    last_q <= '0;
    else if (fire && !directed) last_q <= pick_idx;
  end

  AST_DIST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fire && !directed) |-> $onehot0(tgt_o)); // R7

  AST_TGT_IN_DEST: assert property (@(posedge clk) disable iff (rst)
    (tgt_o & ~dest_i) == '0); // R6

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_TGT_ELIG: assert property (@(posedge clk) disable iff (rst)
      tgt_o[c] |-> ((prio_i > cpu_prio_i[c*PRIO_W +: PRIO_W]) && !raised_i[c])); // R10
  end
endmodule

// File: rtl/irq_route_gate.sv
`timescale 1ns/1ps
module irq_route_gate
  import irq_rg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 4,
  parameter int NUM_EXT = 6,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          req_i,
  input  logic                        cfg_we_i,
  input  logic [SRC_W-1:0]            cfg_idx_i,
  input  logic                        cfg_sel_i,
  input  logic [31:0]                 cfg_wdata_i,
  output logic [31:0]                 cfg_rdata_o,
  input  logic [NUM_CPU*PRIO_W-1:0]   cpu_prio_i,
  input  logic [NUM_SRC*NUM_CPU-1:0]  raised_i,
  input  logic [NUM_SRC-1:0]          act_clr_i,
  output logic [NUM_SRC*NUM_CPU-1:0]  deliver_o
);
  vp_cfg_t                         cfg_a   [NUM_SRC];
  logic [31:0]                     vpw_a   [NUM_SRC];
  logic [31:0]                     dsw_a   [NUM_SRC];
  logic [NUM_SRC-1:0]              act_v;
  logic [NUM_SRC-1:0]              evt_v;
  logic [NUM_SRC-1:0]              drop_v;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] dest_v;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] tgt_v;
  logic [NUM_SRC*NUM_CPU-1:0]      dlv_q;
  logic [31:0]                     rd_word;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit;
    assign hit = cfg_we_i && (cfg_idx_i == SRC_W'(s));

    irq_rg_cfg #(.NUM_CPU(NUM_CPU), .IS_EXT(s < NUM_EXT)) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .we_vp_i    (hit && !cfg_sel_i),
      .we_dst_i   (hit && cfg_sel_i),
      .wdata_i    (cfg_wdata_i),
      .act_set_i  (|tgt_v[s]),
      .act_clr_i  (act_clr_i[s] | drop_v[s]),
      .cfg_o      (cfg_a[s]),
      .act_o      (act_v[s]),
      .dest_o     (dest_v[s]),
      .vp_word_o  (vpw_a[s]),
      .dst_word_o (dsw_a[s])
    );

    irq_rg_detect u_det (
      .clk      (clk),
      .rst      (rst),
      .req_i    (req_i[s]),
      .pol_i    (cfg_a[s].pol),
      .sense_i  (cfg_a[s].sense),
      .act_i    (act_v[s]),
      .assert_o (evt_v[s]),
      .drop_o   (drop_v[s])
    );

    irq_rg_route #(.NUM_CPU(NUM_CPU)) u_rt (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt_v[s]),
      .act_i      (act_v[s]),
      .mask_i     (cfg_a[s].mask),
      .mode_i     (cfg_a[s].mode),
      .prio_i     (cfg_a[s].prio),
      .dest_i     (dest_v[s]),
      .cpu_prio_i (cpu_prio_i),
      .raised_i   (raised_i[s*NUM_CPU +: NUM_CPU]),
      .tgt_o      (tgt_v[s])
    );

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
      $past(act_v[s]) |-> (dlv_q[s*NUM_CPU +: NUM_CPU] == '0)); // R4

    AST_GATED_ONLY: assert property (@(posedge clk) disable iff (rst)
      (|dlv_q[s*NUM_CPU +: NUM_CPU]) |->
        $past(!cfg_a[s].mask && (cfg_a[s].prio != '0) && (|dest_v[s]))); // R3

    AST_PULSE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      (|dlv_q[s*NUM_CPU +: NUM_CPU]) |-> act_v[s]); // R10
  end

  always_ff @(posedge clk) begin
    if (rst) dlv_q <= '0;
    else     dlv_q <= tgt_v;
  end
  assign deliver_o = dlv_q;

  always_comb begin
    rd_word = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cfg_idx_i == SRC_W'(s)) rd_word = cfg_sel_i ? dsw_a[s] : vpw_a[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata_o <= '0;
    else     cfg_rdata_o <= rd_word;
  end
endmodule

// File: tb/tb_irq_route_gate.sv
`timescale 1ns/1ps
module tb_irq_route_gate;
  localparam int NS = 8;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] req = '0;
  logic          we = 1'b0;
  logic [2:0]    idx = '0;
  logic          sel = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [15:0]   cprio = '0;
  logic [31:0]   raised = '0;
  logic [NS-1:0] aclr = '0;
  logic [31:0]   dlv;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_gate #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_EXT(6)) dut (
    .clk(clk), .rst(rst), .req_i(req), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_sel_i(sel), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .cpu_prio_i(cprio), .raised_i(raised), .act_clr_i(aclr), .deliver_o(dlv)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] row(int s);
    return 32'(dlv[s*NC +: NC]);
  endfunction

  task automatic wr(int s, bit sl, logic [31:0] d);
    idx = 3'(s); sel = sl; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(int s, bit sl, output logic [31:0] d);
    idx = 3'(s); sel = sl;
    tick();
    d = rdata;
  endtask

  task automatic pulse(int s, logic [31:0] exp, string tag);
    req[s] = 1'b1;
    tick();
    chk(tag, row(s), exp);
    req[s] = 1'b0;
    tick();
  endtask

  task automatic clr(int s);
    aclr[s] = 1'b1;
    tick();
    aclr[s] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 deliver idle", dlv, 32'h0);
    rd(0, 0, d); chk("R1 vp reset src0", d, 32'hA000_0000);
    rd(0, 1, d); chk("R1 dst reset src0", d, 32'h0);
    rd(7, 0, d); chk("R1 vp reset src7", d, 32'hA000_0000);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(0, 1, 32'h1);
    wr(0, 0, 32'h8005_0010);
    pulse(0, 0, "R3 masked");
    wr(0, 0, 32'h0000_0010);
    pulse(0, 0, "R3 prio zero");
    wr(0, 0, 32'h0005_0010);
    wr(0, 1, 32'h0);
    pulse(0, 0, "R3 empty dest");
    rd(0, 0, d); chk("R2 R3 vp readback no activity", d, 32'h0005_0010);
    wr(0, 1, 32'h1);
    pulse(0, 32'h1, "R3 open gate delivers");
    clr(0);
  endtask

  task automatic t_directed();
    logic [31:0] d;
    wr(1, 1, 32'hB);
    wr(1, 0, 32'h0006_0021);
    pulse(1, 32'hB, "R6 directed all listed");
    rd(1, 0, d); chk("R10 activity set", d, 32'h4006_0021);
    pulse(1, 32'h0, "R4 refused while active");
    clr(1);
    rd(1, 0, d); chk("R11 activity cleared", d, 32'h0006_0021);
    pulse(1, 32'hB, "R11 accepted after clear");
    clr(1);
  endtask

  task automatic t_elig();
    logic [31:0] d;
    cprio = 16'h0070;
    pulse(1, 32'h9, "R10 cpu1 task prio above");
    clr(1);
    cprio = 16'h0076;
    pulse(1, 32'h8, "R10 equal prio excluded");
    clr(1);
    raised[1*NC+3] = 1'b1;
    pulse(1, 32'h0, "R10 raised excluded");
    rd(1, 0, d); chk("R10 no activity when none eligible", d, 32'h0006_0021);
    cprio = '0; raised = '0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(2, 1, 32'h1);
    wr(2, 0, 32'h0043_0005);
    req[2] = 1'b1;
    tick(); chk("R5 level delivers", row(2), 32'h1);
    tick(); chk("R4 held level no repeat", row(2), 32'h0);
    rd(2, 0, d); chk("R5 level active", d, 32'h4043_0005);
    wr(2, 0, 32'h0003_0009);
    rd(2, 0, d); chk("R8 sense locked while active", d, 32'h4043_0009);
    aclr[2] = 1'b1;
    tick(); chk("R5 no pulse during clear", row(2), 32'h0);
    aclr[2] = 1'b0;
    tick(); chk("R5 held level taken again", row(2), 32'h1);
    req[2] = 1'b0;
    tick();
    rd(2, 0, d); chk("R5 drop clears activity", d, 32'h0043_0009);
    wr(2, 0, 32'h0003_0009);
    rd(2, 0, d); chk("R8 sense writable when idle", d, 32'h0003_0009);
  endtask

  task automatic t_polarity();
    req[3] = 1'b1;
    wr(3, 1, 32'h4);
    wr(3, 0, 32'h0083_0007);
    tick();
    chk("R12 no pulse at idle high", row(3), 32'h0);
    req[3] = 1'b0;
    tick(); chk("R12 falling input fires", row(3), 32'h4);
    req[3] = 1'b1;
    tick(); chk("R12 rising input quiet", row(3), 32'h0);
    clr(3);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(6, 0, 32'h00C3_0001);
    rd(6, 0, d); chk("R8 internal source no sense", d, 32'h0003_0001);
    wr(5, 1, 32'hFFFF_FFFF);
    rd(5, 1, d); chk("R9 dest write mask", d, 32'hC000_000F);
    wr(5, 1, 32'h0);
  endtask

  task automatic t_distrib();
    wr(4, 1, 32'hF);
    wr(4, 0, 32'h2002_0044);
    pulse(4, 32'h2, "R7 first after cpu0"); clr(4);
    pulse(4, 32'h4, "R7 next cpu2"); clr(4);
    pulse(4, 32'h8, "R7 next cpu3"); clr(4);
    pulse(4, 32'h1, "R7 wrap to cpu0"); clr(4);
    wr(4, 1, 32'h5);
    pulse(4, 32'h4, "R7 skip unlisted"); clr(4);
    pulse(4, 32'h1, "R7 wrap over gap"); clr(4);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_gate();
    t_directed();
    t_elig();
    t_level();
    t_polarity();
    t_fields();
    t_distrib();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule